// File: doc/BRIEF.md
# Flash Word Program Controller

This block sits on the host side of a NOR-style parallel flash device and programs one word at a time. A requester hands it a target address and a data word on a valid/ready handshake. The controller first reads the stored word. If the request would raise any bit from 0 to 1, it refuses the request without touching the device, because only an erase can set bits. Otherwise it sends the device's unlock-and-program write sequence and then keeps reading the target address until the device reports that it has finished.

The controller recognises completion in three ways. The first is a status bit that stops toggling between successive reads. The second is a data-polling bit that comes back equal to the written value. The third, when enabled, is the device's ready/busy pin. When the device raises its internal time-limit flag while still toggling, the controller reads once more to rule out a late completion. After that it writes the return-to-read command and reports failure. A one-cycle done pulse carries a two-bit status code, and the controller then goes back to idle.

States: `C_IDLE` (accept), `C_PRE_RD` (read stored word), `C_UNLOCK` (four bus writes, counted by a step index), `C_POLL_A` (first status read), `C_POLL_B` (each later status read, judged against the one before), `C_RECHK` (extra read after the time-limit flag), `C_RST_WR` (return-to-read write), `C_DONE` (report). The transitions are as follows:
- `C_IDLE` goes to `C_PRE_RD` when a request is accepted.
- `C_PRE_RD` goes to `C_DONE` on reject and to `C_UNLOCK` otherwise.
- `C_UNLOCK` goes to `C_POLL_A` after the fourth write.
- `C_POLL_A` goes to `C_POLL_B`.
- `C_POLL_B` goes to `C_DONE` on completion, to `C_RECHK` on the time-limit flag, and stays in `C_POLL_B` otherwise.
- `C_RECHK` goes to `C_DONE` on completion and to `C_RST_WR` otherwise.
- `C_RST_WR` goes to `C_DONE`.
- `C_DONE` goes to `C_IDLE`.

Top module: `flash_prog_ctrl`

## Requirements
- R1: `req_ready` is high only in idle. It is low from the cycle after a request is accepted, through the done cycle, and is high again in the cycle after done.
- R2: Each request starts with one read of the target address. If `req_data & ~stored` is nonzero, the controller makes no bus write and finishes with status 2.
- R3: An accepted legal request produces exactly four bus writes, in this order: (0x555, 0xAA), (0x2AA, 0x55), (0x555, 0xA0), then (target address, data).
- R4: Every strobe (`fl_ce_n` with `fl_we_n` or `fl_oe_n`) is low for exactly PULSE_CYC cycles. Address and write data are present at least one cycle before the falling edge and stay unchanged until at least one cycle after the rising edge. Accesses are separated by at least GAP_CYC+1 high cycles. `fl_we_n` and `fl_oe_n` are never low together.
- R5: Reads of the target after the fourth write are status reads. If bit 6 is equal in two successive status reads, the controller finishes with status 0.
- R6: A status read whose bit 7 equals bit 7 of the written data, from the second status read on, finishes with status 0.
- R7: When `use_rdy` is 1, `fl_rdy` high at the end of a status read from the second one on finishes with status 0. When `use_rdy` is 0, `fl_rdy` is ignored.
- R8: If a status read shows bit 5 high while bit 6 differs from the previous read, the controller makes one more read. If that read shows neither completion condition, the controller writes 0xF0 to the target address and finishes with status 1.
- R9: If the extra read after the time-limit flag shows bit 6 unchanged or bit 7 matching, the controller finishes with status 0 and makes no 0xF0 write.
- R10: `done` is a single-cycle pulse, `status` is 0, 1 or 2 while it is high, and the controller accepts a new request afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Program request present |
| req_ready | output | 1 | Controller can accept a request |
| req_addr | input | AW | Target word address |
| req_data | input | DW | Word to program |
| use_rdy | input | 1 | Treat the ready/busy pin as a completion source |
| done | output | 1 | One-cycle completion pulse |
| status | output | 2 | 0 success, 1 device time-limit failure, 2 rejected 0-to-1 |
| fl_addr | output | AW | Flash address bus |
| fl_dq_out | output | DW | Flash write data |
| fl_dq_oe | output | 1 | Controller drives the data bus |
| fl_dq_in | input | DW | Flash read data |
| fl_ce_n | output | 1 | Chip enable, active low |
| fl_we_n | output | 1 | Write enable, active low |
| fl_oe_n | output | 1 | Output enable, active low |
| fl_rdy | input | 1 | Device ready (high) / busy (low) |

## Verification
Two functions can coincide here: the time-limit flag and the completion of programming. A bench flash model produces this case by raising bit 5 on one toggling status read and then finishing the program before the next read. A correct controller must then resolve the race on its extra read, report status 0 and never send the return-to-read write. The same model also provides a true time-out case, where the controller must report status 1 after exactly one 0xF0 write. It also provides completion cases in which only bit 6, only bit 7 or only the ready pin signals the end. These are judged by whether the model was still mid-operation when done arrived.

// File: rtl/flash_prog_pkg.sv
package flash_prog_pkg;

    typedef enum logic [2:0] {
        C_IDLE,
        C_PRE_RD,
        C_UNLOCK,
        C_POLL_A,
        C_POLL_B,
        C_RECHK,
        C_RST_WR,
        C_DONE
    } ctl_state_e;

    typedef enum logic [1:0] {
        B_IDLE,
        B_SETUP,
        B_LOW,
        B_GAP
    } bus_phase_e;

    localparam logic [1:0] ST_OK  = 2'd0;
    localparam logic [1:0] ST_TMO = 2'd1;
    localparam logic [1:0] ST_REJ = 2'd2;

endpackage

// File: rtl/flash_bus_cycle.sv
module flash_bus_cycle
    import flash_prog_pkg::*;
#(
    parameter int AW        = 12,
    parameter int DW        = 16,
    parameter int PULSE_CYC = 2,
    parameter int GAP_CYC   = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic          wr,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] wdata,
    output logic          fin,
    output logic [DW-1:0] rdata,
    output logic [AW-1:0] fl_addr,
    output logic [DW-1:0] fl_dq_out,
    output logic          fl_dq_oe,
    input  logic [DW-1:0] fl_dq_in,
    output logic          fl_ce_n,
    output logic          fl_we_n,
    output logic          fl_oe_n
);

    localparam int CMAX = (PULSE_CYC > GAP_CYC) ? PULSE_CYC : GAP_CYC;
    localparam int CW   = $clog2(CMAX + 1);

    bus_phase_e    phase_q;
    logic [CW-1:0] cnt_q;
    logic          wr_q;

    assign fin = (phase_q == B_GAP) && (cnt_q == '0);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            phase_q   <= B_IDLE;
            cnt_q     <= '0;
            wr_q      <= 1'b0;
            fl_addr   <= '0;
            fl_dq_out <= '0;
            rdata     <= '0;
        end else if (start && (phase_q == B_IDLE || fin)) begin
            fl_addr   <= addr;
            fl_dq_out <= wdata;
            wr_q      <= wr;
            phase_q   <= B_SETUP;
        end else begin
            unique case (phase_q)
                B_IDLE: phase_q <= B_IDLE;
                B_SETUP: begin
                    phase_q <= B_LOW;
                    cnt_q   <= CW'(PULSE_CYC - 1);
                end
                B_LOW: begin
                    if (cnt_q == '0) begin
                        rdata   <= fl_dq_in;
                        phase_q <= B_GAP;
                        cnt_q   <= CW'(GAP_CYC - 1);
                    end else begin
                        cnt_q <= cnt_q - 1'b1;
                    end
                end
                B_GAP: begin
                    if (cnt_q == '0) phase_q <= B_IDLE;
                    else             cnt_q   <= cnt_q - 1'b1;
                end
                default: phase_q <= B_IDLE;
            endcase
        end
    end

    always_comb begin
        fl_ce_n  = (phase_q != B_LOW);
        fl_we_n  = !((phase_q == B_LOW) && wr_q);
        fl_oe_n  = !((phase_q == B_LOW) && !wr_q);
        fl_dq_oe = wr_q && (phase_q != B_IDLE);
    end

    // R4: address unchanged over a strobe
    p_addr_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!fl_ce_n && $past(!fl_ce_n)) |-> (fl_addr == $past(fl_addr)));
    // R4: address set up a cycle ahead of the falling edge
    p_addr_setup_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(fl_ce_n) |-> (fl_addr == $past(fl_addr)));
    // R4: write data still driven and unchanged after the rising edge
    p_data_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(fl_we_n) |-> (fl_dq_oe && fl_dq_out == $past(fl_dq_out)));
    // R4: never write and read enables together
    p_one_strobe_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !(!fl_we_n && !fl_oe_n));

endmodule

// File: rtl/flash_poll_judge.sv
module flash_poll_judge #(
    parameter int DW = 16
) (
    input  logic [DW-1:0] prev_rd,
    input  logic [DW-1:0] cur_rd,
    input  logic          tgt_bit7,
    input  logic          rdy_ok,
    output logic          complete,
    output logic          limit_hit
);

    logic toggled;

    always_comb begin
        toggled   = prev_rd[6] ^ cur_rd[6];
        complete  = !toggled || (cur_rd[7] == tgt_bit7) || rdy_ok;
        limit_hit = cur_rd[5] && toggled;
    end

endmodule

// File: rtl/flash_prog_ctrl.sv
module flash_prog_ctrl
    import flash_prog_pkg::*;
#(
    parameter int AW        = 12,
    parameter int DW        = 16,
    parameter int PULSE_CYC = 2,
    parameter int GAP_CYC   = 2,
    parameter int UNL_ADDR1 = 'h555,
    parameter int UNL_ADDR2 = 'h2AA,
    parameter int UNL_DATA1 = 'hAA,
    parameter int UNL_DATA2 = 'h55,
    parameter int PGM_CMD   = 'hA0,
    parameter int RST_CMD   = 'hF0
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_valid,
    output logic          req_ready,
    input  logic [AW-1:0] req_addr,
    input  logic [DW-1:0] req_data,
    input  logic          use_rdy,
    output logic          done,
    output logic [1:0]    status,
    output logic [AW-1:0] fl_addr,
    output logic [DW-1:0] fl_dq_out,
    output logic          fl_dq_oe,
    input  logic [DW-1:0] fl_dq_in,
    output logic          fl_ce_n,
    output logic          fl_we_n,
    output logic          fl_oe_n,
    input  logic          fl_rdy
);

    ctl_state_e    state_q, state_d;
    logic [1:0]    step_q, step_d, wstep;
    logic [1:0]    stat_q, stat_d;
    logic [AW-1:0] addr_q;
    logic [DW-1:0] data_q, prev_q;
    logic          take, prev_ld;

    logic          bus_start, bus_wr, bus_fin;
    logic [AW-1:0] bus_addr, cmd_a;
    logic [DW-1:0] bus_wdata, cmd_d, bus_rdata;
    logic          jg_done, jg_limit;

    flash_bus_cycle #(
        .AW(AW), .DW(DW), .PULSE_CYC(PULSE_CYC), .GAP_CYC(GAP_CYC)
    ) u_bus (
        .clk(clk), .rst_n(rst_n),
        .start(bus_start), .wr(bus_wr), .addr(bus_addr), .wdata(bus_wdata),
        .fin(bus_fin), .rdata(bus_rdata),
        .fl_addr(fl_addr), .fl_dq_out(fl_dq_out), .fl_dq_oe(fl_dq_oe),
        .fl_dq_in(fl_dq_in), .fl_ce_n(fl_ce_n), .fl_we_n(fl_we_n),
        .fl_oe_n(fl_oe_n)
    );

    flash_poll_judge #(.DW(DW)) u_judge (
        .prev_rd(prev_q), .cur_rd(bus_rdata), .tgt_bit7(data_q[7]),
        .rdy_ok(use_rdy && fl_rdy), .complete(jg_done), .limit_hit(jg_limit)
    );

    // command word for the next write of the sequence
    always_comb begin
        wstep = (state_q == C_PRE_RD) ? 2'd0 : step_q + 2'd1;
        unique case (wstep)
            2'd0:    begin cmd_a = AW'(UNL_ADDR1); cmd_d = DW'(UNL_DATA1); end
            2'd1:    begin cmd_a = AW'(UNL_ADDR2); cmd_d = DW'(UNL_DATA2); end
            2'd2:    begin cmd_a = AW'(UNL_ADDR1); cmd_d = DW'(PGM_CMD);   end
            default: begin cmd_a = addr_q;         cmd_d = data_q;         end
        endcase
    end

    // next state and bus requests
    always_comb begin
        state_d   = state_q;
        step_d    = step_q;
        stat_d    = stat_q;
        take      = 1'b0;
        prev_ld   = 1'b0;
        bus_start = 1'b0;
        bus_wr    = 1'b0;
        bus_addr  = addr_q;
        bus_wdata = data_q;
        unique case (state_q)
            C_IDLE: if (req_valid) begin
                take      = 1'b1;
                bus_start = 1'b1;
                bus_addr  = req_addr;
                state_d   = C_PRE_RD;
            end
            C_PRE_RD: if (bus_fin) begin
                if (|(data_q & ~bus_rdata)) begin
                    stat_d  = ST_REJ;
                    state_d = C_DONE;
                end else begin
                    step_d    = 2'd0;
                    bus_start = 1'b1;
                    bus_wr    = 1'b1;
                    bus_addr  = cmd_a;
                    bus_wdata = cmd_d;
                    state_d   = C_UNLOCK;
                end
            end
            C_UNLOCK: if (bus_fin) begin
                bus_start = 1'b1;
                if (step_q == 2'd3) begin
                    state_d = C_POLL_A;
                end else begin
                    step_d    = wstep;
                    bus_wr    = 1'b1;
                    bus_addr  = cmd_a;
                    bus_wdata = cmd_d;
                end
            end
            C_POLL_A: if (bus_fin) begin
                prev_ld   = 1'b1;
                bus_start = 1'b1;
                state_d   = C_POLL_B;
            end
            C_POLL_B: if (bus_fin) begin
                prev_ld = 1'b1;
                if (jg_done) begin
                    stat_d  = ST_OK;
                    state_d = C_DONE;
                end else begin
                    bus_start = 1'b1;
                    if (jg_limit) state_d = C_RECHK;
                end
            end
            C_RECHK: if (bus_fin) begin
                if (jg_done) begin
                    stat_d  = ST_OK;
                    state_d = C_DONE;
                end else begin
                    stat_d    = ST_TMO;
                    bus_start = 1'b1;
                    bus_wr    = 1'b1;
                    bus_wdata = DW'(RST_CMD);
                    state_d   = C_RST_WR;
                end
            end
            C_RST_WR: if (bus_fin) state_d = C_DONE;
            C_DONE:   state_d = C_IDLE;
            default:  state_d = C_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= C_IDLE;
            step_q  <= '0;
            stat_q  <= ST_OK;
            addr_q  <= '0;
            data_q  <= '0;
            prev_q  <= '0;
        end else begin
            state_q <= state_d;
            step_q  <= step_d;
            stat_q  <= stat_d;
            if (take) begin
                addr_q <= req_addr;
                data_q <= req_data;
            end
            if (prev_ld) prev_q <= bus_rdata;
        end
    end

    always_comb begin
        req_ready = (state_q == C_IDLE);
        done      = (state_q == C_DONE);
        status    = stat_q;
    end

    // R1: ready drops right after acceptance
    p_ready_drop_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> !req_ready);
    // R10: done lasts one cycle and is followed by readiness
    p_done_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (!done && req_ready));
    // R10: legal status code while reporting
    p_status_legal_r10: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (status != 2'd3));
    // R2: no write strobe can precede the stored-word read of a request
    p_read_first_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> fl_we_n);

endmodule

// File: tb/flash_prog_ctrl_bench.sv
module flash_prog_ctrl_bench;

    localparam int AW = 12;
    localparam int DW = 16;
    localparam int PULSE = 2;
    localparam int GAP = 2;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0;
    logic          req_ready;
    logic [AW-1:0] req_addr = '0;
    logic [DW-1:0] req_data = '0;
    logic          use_rdy = 1'b0;
    logic          done;
    logic [1:0]    status;
    logic [AW-1:0] fl_addr;
    logic [DW-1:0] fl_dq_out, fl_dq_in, rd_val;
    logic          fl_dq_oe, fl_ce_n, fl_we_n, fl_oe_n, fl_rdy;

    always #5 clk = ~clk;

    flash_prog_ctrl #(.AW(AW), .DW(DW), .PULSE_CYC(PULSE), .GAP_CYC(GAP)) u_flash_prog_ctrl (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_addr(req_addr), .req_data(req_data), .use_rdy(use_rdy),
        .done(done), .status(status), .fl_addr(fl_addr), .fl_dq_out(fl_dq_out),
        .fl_dq_oe(fl_dq_oe), .fl_dq_in(fl_dq_in), .fl_ce_n(fl_ce_n),
        .fl_we_n(fl_we_n), .fl_oe_n(fl_oe_n), .fl_rdy(fl_rdy)
    );

    int checks = 0, errors = 0;
    int cycles = 0;
    bit finished = 1'b0;

    // ---------------- bench flash model ----------------
    logic [DW-1:0] mem [0:4095];
    int  m_mode = 0, m_L = 1;
    int  op_id = 0, seen_op = 0, kick_id = 0, seen_kick = 0;
    bit  m_busy = 0, m_dq5 = 0, m_tog = 0, m_rdy_hi = 0;
    int  m_post = 0, m_rdcnt = 0, m_stage = 0;
    logic [DW-1:0] m_pd = '0;
    int  nwr = 0, nrst = 0;
    logic [AW-1:0] log_a [0:7];
    logic [DW-1:0] log_d [0:7];
    bit  p_ce = 1, p_we = 1, p_oe = 1;
    logic [AW-1:0] p_a = '0, fa = '0;
    logic [DW-1:0] p_d = '0, fd = '0;
    int  low_len = 0, hi_len = 100;
    int  pulse_bad = 0, gap_bad = 0, setup_bad = 0, hold_bad = 0;
    int  ready_viol = 0;
    bit  in_op = 0;

    always_comb begin
        if (m_busy)
            rd_val = {8'h00, ~m_pd[7], m_tog, m_dq5, 5'b0};
        else if (m_post > 0 && m_mode == 4)
            rd_val = {mem[fl_addr][15:7], m_tog, mem[fl_addr][5:0]};
        else if (m_post > 0)
            rd_val = {mem[fl_addr][15:8], ~m_pd[7], 1'b0, mem[fl_addr][5:0]};
        else
            rd_val = mem[fl_addr];
    end
    assign fl_dq_in = (!fl_oe_n && !fl_ce_n) ? rd_val : '0;
    assign fl_rdy   = !m_busy || m_rdy_hi;

    always @(posedge clk) begin
        if (op_id != seen_op) begin seen_op = op_id; nwr = 0; nrst = 0; end
        if (kick_id != seen_kick) begin
            seen_kick = kick_id; m_busy = 0; m_post = 0; m_dq5 = 0; m_stage = 0; m_rdy_hi = 0;
        end
        if (rst_n) begin
            if (p_ce && !fl_ce_n) begin
                if (fl_addr != p_a) setup_bad++;
                if (!fl_we_n && fl_dq_out != p_d) setup_bad++;
                if (hi_len < GAP + 1) gap_bad++;
                low_len = 1; fa = fl_addr; fd = fl_dq_out;
            end else if (!p_ce && !fl_ce_n) begin
                low_len++;
                if (fl_addr != fa || (!fl_we_n && fl_dq_out != fd)) hold_bad++;
            end else if (!p_ce && fl_ce_n) begin
                hi_len = 1;
                if (low_len != PULSE) pulse_bad++;
                if (!p_we) begin
                    if (fl_addr != fa || fl_dq_out != fd || !fl_dq_oe) hold_bad++;
                    model_write(fa, fd);
                end
                if (!p_oe) model_read_end();
            end else begin
                hi_len++;
            end
        end
        p_ce = fl_ce_n; p_we = fl_we_n; p_oe = fl_oe_n; p_a = fl_addr; p_d = fl_dq_out;
    end

    function automatic void model_write(logic [AW-1:0] a, logic [DW-1:0] d);
        if (nwr < 8) begin log_a[nwr] = a; log_d[nwr] = d; end
        nwr++;
        if (m_busy) begin
            if (m_dq5 && d[7:0] == 8'hF0) begin m_busy = 0; nrst++; end
        end else if (d[7:0] == 8'hF0) begin
            m_stage = 0;
        end else begin
            case (m_stage)
                0: m_stage = (a == 12'h555 && d == 16'h00AA) ? 1 : 0;
                1: m_stage = (a == 12'h2AA && d == 16'h0055) ? 2 : 0;
                2: m_stage = (a == 12'h555 && d == 16'h00A0) ? 3 : 0;
                default: begin
                    mem[a] = mem[a] & d; m_pd = d; m_stage = 0;
                    m_rdcnt = 0; m_tog = 0; m_dq5 = 0; m_rdy_hi = 0; m_post = 0;
                    m_busy = !(m_L == 0 && (m_mode == 0 || m_mode >= 4));
                    if (!m_busy && m_mode >= 4) m_post = 8;
                    if (m_mode == 3 && m_L == 0) m_rdy_hi = 1;
                end
            endcase
        end
    endfunction

    function automatic void model_read_end();
        if (m_busy) begin
            m_tog = !m_tog; m_rdcnt++;
            case (m_mode)
                1: if (m_rdcnt >= m_L) m_dq5 = 1;
                2: if (m_rdcnt == m_L) m_dq5 = 1; else if (m_rdcnt > m_L) m_busy = 0;
                3: begin
                    if (m_rdcnt >= m_L) m_rdy_hi = 1;
                    if (m_rdcnt >= m_L + 8) m_busy = 0;
                end
                default: if (m_rdcnt >= m_L) begin
                    m_busy = 0; m_post = (m_mode >= 4) ? 8 : 0;
                end
            endcase
        end else if (m_post > 0) begin
            m_tog = !m_tog; m_post--;
        end
    endfunction

    // ---------------- bench checking ----------------
    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic int exp_status(logic [DW-1:0] old, logic [DW-1:0] nw, int mode);
        if (|(nw & ~old)) return 2;
        if (mode == 1) return 1;
        return 0;
    endfunction

    function automatic logic [AW-1:0] exp_wa(int i, logic [AW-1:0] a);
        case (i) 0: return 12'h555; 1: return 12'h2AA; 2: return 12'h555; default: return a; endcase
    endfunction

    function automatic logic [DW-1:0] exp_wd(int i, logic [DW-1:0] d);
        case (i) 0: return 16'h00AA; 1: return 16'h0055; 2: return 16'h00A0;
            3: return d; default: return 16'h00F0; endcase
    endfunction

    always @(negedge clk) if (in_op && req_ready) ready_viol++;

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000 && !finished) begin
            errors++;
            $display("FAIL watchdog actual=%0d expected=%0d", cycles, 150000);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    task automatic run_op(input logic [AW-1:0] a, input logic [DW-1:0] d,
                          input int mode, input int L, input bit urdy);
        logic [DW-1:0] old;
        int es, rv0, cyc, nexp;
        bit early;
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        m_mode = mode; m_L = L; use_rdy = urdy; op_id++;
        old = mem[a];
        es = exp_status(old, d, mode);
        rv0 = ready_viol;
        req_addr = a; req_data = d; req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0; in_op = 1;
        cyc = 0;
        while (!done && cyc < 5000) begin @(negedge clk); cyc++; end
        in_op = 0;
        chk(done, "R10", "done seen", done, 1);
        chk(status == es[1:0], (es == 2) ? "R2" : (es == 1) ? "R8" : "R9", "status",
            status, es);
        nexp = (es == 2) ? 0 : (es == 1) ? 5 : 4;
        chk(nwr == nexp, "R3", "write count", nwr, nexp);
        for (int i = 0; i < nexp && i < 8; i++) begin
            chk(log_a[i] == exp_wa(i, a) && log_d[i] == exp_wd(i, d), "R3",
                "write order", {log_a[i], log_d[i]}, {exp_wa(i, a), exp_wd(i, d)});
        end
        if (es == 1) chk(nrst == 1 && !m_busy, "R8", "reset accepted", nrst, 1);
        if (es == 2) chk(mem[a] == old, "R2", "stored word kept", mem[a], old);
        early = m_busy || (m_post > 0);
        if (es == 0 && mode == 3) chk(early == urdy, "R7", "ready pin use", early, urdy);
        if (es == 0 && mode == 4) chk(early, "R6", "bit7 completion", early, 1);
        if (es == 0 && mode == 5) chk(early, "R5", "bit6 completion", early, 1);
        if (es == 0 && mode == 2) chk(nrst == 0, "R9", "no reset on race", nrst, 0);
        chk(ready_viol == rv0, "R1", "ready low while busy", ready_viol - rv0, 0);
        @(negedge clk);
        chk(req_ready && !done, "R1", "ready after done", {req_ready, done}, 2'b10);
        kick_id++;
        @(negedge clk);
    endtask

    initial begin
        void'($urandom(32'd1234));
        for (int i = 0; i < 4096; i++) mem[i] = 16'hFFFF;
        repeat (3) @(negedge clk);
        chk(req_ready && !done && fl_ce_n && fl_we_n && fl_oe_n, "R1", "reset state",
            {req_ready, done, fl_ce_n, fl_we_n, fl_oe_n}, 5'b10111);
        rst_n = 1'b1;
        // directed corner cases
        run_op(12'h010, 16'h1234, 0, 3, 0);      // plain completion
        run_op(12'h010, 16'h1235, 0, 1, 0);      // 0 -> 1 on bit 0: rejected
        run_op(12'h011, 16'h00FF, 0, 0, 0);      // finished before first poll
        run_op(12'h012, 16'h8000, 4, 2, 0);      // bit 7 match only
        run_op(12'h013, 16'h0000, 4, 1, 0);
        run_op(12'h014, 16'h7F00, 5, 3, 0);      // bit 6 stop only
        run_op(12'h015, 16'hFF80, 5, 0, 0);
        run_op(12'h016, 16'h5555, 3, 2, 1);      // ready pin honoured
        run_op(12'h017, 16'h5555, 3, 2, 0);      // ready pin ignored
        run_op(12'h018, 16'hAAAA, 1, 2, 1);      // device time limit
        run_op(12'h019, 16'h0F0F, 2, 1, 0);      // limit flag racing completion
        run_op(12'h01A, 16'hF0F0, 2, 4, 1);
        // constrained random
        for (int k = 0; k < 40; k++) begin
            logic [AW-1:0] a;
            logic [DW-1:0] d;
            int mode, L;
            bit ur;
            a = AW'($urandom % 24);
            mode = $urandom % 6;
            L = 1 + $urandom % 5;
            ur = (mode >= 4) ? 1'b0 : 1'($urandom % 2);
            if ($urandom % 4 == 0) d = mem[a] | DW'(1 << ($urandom % 16));
            else d = mem[a] & DW'($urandom);
            run_op(a, d, mode, L, ur);
        end
        chk(pulse_bad == 0, "R4", "strobe width", pulse_bad, 0);
        chk(gap_bad == 0, "R4", "gap width", gap_bad, 0);
        chk(setup_bad == 0, "R4", "setup", setup_bad, 0);
        chk(hold_bad == 0, "R4", "hold", hold_bad, 0);
        finished = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule